// File: doc/BRIEF.md
# Self-Triggered Hit Detector and Cluster Formatter

This block watches a row of detector channels whose ADC samples arrive in parallel on every edge of a free-running sample clock. No trigger or accept signal exists. Each channel decides for itself when it has seen a pulse peak, by comparing each sample with the programmable threshold and with the samples on either side of it in time. A cycle counter gives every sample an absolute time stamp. The moment at which the pulse crossed the threshold is then refined to sixteenths of a cycle by linear interpolation.

For each accepted peak the block builds one cluster record. The record holds the channel address, the refined time, the peak charge, and the charges that the left and right neighbour channels carried in the same cycle. The outermost channels take their outer neighbour charge from two edge inputs, which a neighbouring cell drives. When two adjacent channels peak together, the weaker one is suppressed, so that each cluster leaves the block once. Records leave on a valid/ready stream through a small queue. A stalled consumer never holds up the sample pipeline: records that cannot be kept are dropped, and a sticky flag reports the loss.

Top module: `selftrig_hitfmt`

## Requirements
- R1: A time-stamp counter starts at 0 on the first active clock edge after reset and counts every cycle. The first sample presented after reset release (two edges after `rst_n` rises) carries stamp 0. The upper 16 bits of `rec_time_o` hold the stamp of the sample taken one cycle before the peak.
- R2: A channel declares a hit on sample P, which has predecessor A and successor N, when P > threshold, P >= A and P > N. No external signal takes part in this decision.
- R3: A record carries the following fields:
  - `rec_addr_o`: the channel index.
  - `rec_q_o`: the peak sample P.
  - `rec_ql_o` and `rec_qr_o`: the samples of channels index-1 and index+1 in the peak cycle.
  - For channel 0, `rec_ql_o` comes from `edge_lo_i`. For the last channel, `rec_qr_o` comes from `edge_hi_i`. Both edge inputs are taken in the same cycle as the peak.
- R4: The low 4 bits of `rec_time_o` are the sub-cycle fraction. If A <= threshold, the fraction is floor(16*(threshold-A)/(P-A)). Otherwise it is 0.
- R5: A hitting channel is suppressed when its left neighbour also hits with a charge greater than or equal to its own. It is also suppressed when its right neighbour hits with a strictly greater charge. Two adjacent channels are therefore never both recorded.
- R6: At most one record is written per cycle, taken from the lowest-indexed channel that is not suppressed. Any other unsuppressed hit in that cycle is dropped and sets `lost_o`.
- R7: Records wait in a 4-entry first-in first-out queue and leave in arrival order. While `rec_valid_o` is high and `rec_ready_i` is low, the output record stays unchanged.
- R8: A record that arrives while the queue is full and not being read is dropped, and `lost_o` is set. `lost_o` stays high until reset. Hits that follow are still detected and queued once space frees.
- R9: While reset is held and directly after it, `rec_valid_o` and `lost_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thr_i | input | 12 | Hit threshold |
| samples_i | input | 96 | Eight 12-bit samples, channel k at bits [12k+11:12k] |
| edge_lo_i | input | 12 | Sample of the channel left of channel 0 |
| edge_hi_i | input | 12 | Sample of the channel right of channel 7 |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_addr_o | output | 3 | Channel index of the record |
| rec_time_o | output | 20 | Coarse stamp (upper 16 bits) and fraction (lower 4 bits) |
| rec_q_o | output | 12 | Peak charge |
| rec_ql_o | output | 12 | Left neighbour charge |
| rec_qr_o | output | 12 | Right neighbour charge |
| lost_o | output | 1 | Sticky record-loss flag |

## Verification
The bench feeds pulses at both ends of the row, where the neighbour charge must come from an edge input. A design that indexes the wrong side would report a charge from inside the row or a zero. A flat-topped pulse and a pulse that never rises above the threshold test the strict and non-strict comparisons: a wrong comparison gives a duplicate record or a spurious one. Adjacent peaks, both equal and unequal, test the tie-break, since a symmetric rule would send both records or neither. A stalled consumer with more hits than the queue can hold, followed by a fresh hit after draining, shows whether overflow drops the right records, keeps the order and leaves detection running.

// File: rtl/hitfmt_pkg.sv
package hitfmt_pkg;
  localparam int CH_N   = 8;
  localparam int SMP_W  = 12;
  localparam int TS_W   = 16;
  localparam int FR_W   = 4;
  localparam int FIFO_D = 4;
  localparam int AD_W   = $clog2(CH_N);
  localparam int CNT_W  = $clog2(FIFO_D + 1);
  localparam int TIME_W = TS_W + FR_W;

  typedef logic [SMP_W-1:0] smp_t;

  typedef struct packed {
    logic [AD_W-1:0]  addr;
    logic [TS_W-1:0]  coarse;
    logic [FR_W-1:0]  frac;
    smp_t             q;
    smp_t             ql;
    smp_t             qr;
  } hit_rec_t;

  // Position of the threshold crossing between the older sample and the peak,
  // in units of 1/2**FR_W cycle, by restoring division (numerator < divisor).
  function automatic logic [FR_W-1:0] cross_frac(smp_t thr, smp_t older, smp_t peak);
    logic [SMP_W:0]  rem;
    logic [SMP_W:0]  den;
    logic [FR_W-1:0] qv;
    qv = '0;
    if (older <= thr) begin
      rem = {1'b0, smp_t'(thr - older)};
      den = {1'b0, smp_t'(peak - older)};
      for (int b = FR_W - 1; b >= 0; b--) begin
        rem = {rem[SMP_W-1:0], 1'b0};
        if (rem >= den) begin
          rem   = rem - den;
          qv[b] = 1'b1;
        end
      end
    end
    return qv;
  endfunction
endpackage

// File: rtl/hitfmt_chan.sv
module hitfmt_chan
  import hitfmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  smp_t thr_i,
  input  smp_t smp_i,
  output smp_t older_o,
  output smp_t peak_o,
  output logic hit_o
);
  smp_t s_new, s_mid, s_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_new <= '0;
      s_mid <= '0;
      s_old <= '0;
    end else begin
      s_new <= smp_i;
      s_mid <= s_new;
      s_old <= s_mid;
    end
  end

  assign hit_o   = (s_mid > thr_i) && (s_mid >= s_old) && (s_mid > s_new);
  assign peak_o  = s_mid;
  assign older_o = s_old;
endmodule

// File: rtl/hitfmt_pick.sv
module hitfmt_pick
  import hitfmt_pkg::*;
(
  input  logic [CH_N-1:0]            hit_i,
  input  logic [CH_N-1:0][SMP_W-1:0] pk_i,
  input  logic [CH_N-1:0][SMP_W-1:0] old_i,
  input  smp_t                       elo_i,
  input  smp_t                       ehi_i,
  input  smp_t                       thr_i,
  input  logic [TS_W-1:0]            tnow_i,
  output logic                       wr_o,
  output logic                       collide_o,
  output logic [CH_N-1:0]            kept_o,
  output logic [CH_N-1:0]            grant_o,
  output hit_rec_t                   rec_o
);
  logic [CH_N+1:0][SMP_W-1:0] ext;

  assign ext[0]      = elo_i;
  assign ext[CH_N+1] = ehi_i;

  for (genvar x = 0; x < CH_N; x++) begin : g_sup
    logic lose_l, lose_r;
    assign ext[x+1] = pk_i[x];
    if (x == 0) begin : g_l0
      assign lose_l = 1'b0;
    end else begin : g_ln
      assign lose_l = hit_i[x-1] && (pk_i[x-1] >= pk_i[x]);
    end
    if (x == CH_N - 1) begin : g_r0
      assign lose_r = 1'b0;
    end else begin : g_rn
      assign lose_r = hit_i[x+1] && (pk_i[x+1] > pk_i[x]);
    end
    assign kept_o[x] = hit_i[x] && !lose_l && !lose_r;
  end

  assign grant_o   = kept_o & (~kept_o + 1'b1);
  assign wr_o      = |kept_o;
  assign collide_o = |(kept_o & ~grant_o);

  always_comb begin
    smp_t old_sel;
    rec_o   = '0;
    old_sel = '0;
    for (int k = 0; k < CH_N; k++) begin
      if (grant_o[k]) begin
        rec_o.addr = AD_W'(k);
        rec_o.q    = ext[k+1];
        rec_o.ql   = ext[k];
        rec_o.qr   = ext[k+2];
        old_sel    = old_i[k];
      end
    end
    rec_o.coarse = tnow_i - TS_W'(3);
    rec_o.frac   = cross_frac(thr_i, old_sel, rec_o.q);
  end
endmodule

// File: rtl/hitfmt_fifo.sv
module hitfmt_fifo
  import hitfmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  hit_rec_t         rec_i,
  input  logic             rd_i,
  output logic             valid_o,
  output hit_rec_t         rec_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             drop_o
);
  localparam int PW = (FIFO_D > 1) ? $clog2(FIFO_D) : 1;

  hit_rec_t         mem [FIFO_D];
  logic [PW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, pop, push;

  assign full    = (cnt_q == CNT_W'(FIFO_D));
  assign valid_o = (cnt_q != '0);
  assign pop     = valid_o && rd_i;
  assign push    = wr_i && (!full || pop);
  assign drop_o  = wr_i && full && !pop;
  assign rec_o   = mem[rptr_q];
  assign cnt_o   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == PW'(FIFO_D - 1)) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == PW'(FIFO_D - 1)) ? '0 : rptr_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= rec_i;
  end
endmodule

// File: rtl/selftrig_hitfmt.sv
module selftrig_hitfmt
  import hitfmt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SMP_W-1:0]        thr_i,
  input  logic [CH_N*SMP_W-1:0]   samples_i,
  input  logic [SMP_W-1:0]        edge_lo_i,
  input  logic [SMP_W-1:0]        edge_hi_i,
  output logic                    rec_valid_o,
  input  logic                    rec_ready_i,
  output logic [AD_W-1:0]         rec_addr_o,
  output logic [TIME_W-1:0]       rec_time_o,
  output logic [SMP_W-1:0]        rec_q_o,
  output logic [SMP_W-1:0]        rec_ql_o,
  output logic [SMP_W-1:0]        rec_qr_o,
  output logic                    lost_o
);
  logic [1:0]                 rsync;
  logic                       rst_q;
  logic [TS_W-1:0]            tcnt_q, tcnt_d;
  logic [CH_N-1:0][SMP_W-1:0] pk_v, old_v;
  logic [CH_N-1:0]            hit_v, kept, grant;
  smp_t                       elo_0, elo_1, ehi_0, ehi_1;
  logic                       wr, collide, fifo_drop;
  hit_rec_t                   new_rec, out_rec;
  logic [CNT_W-1:0]           fifo_cnt;
  logic                       lost_q, lost_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    hitfmt_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_q),
      .thr_i   (thr_i),
      .smp_i   (samples_i[i*SMP_W +: SMP_W]),
      .older_o (old_v[i]),
      .peak_o  (pk_v[i]),
      .hit_o   (hit_v[i])
    );
  end

  hitfmt_pick u_pick (
    .hit_i     (hit_v),
    .pk_i      (pk_v),
    .old_i     (old_v),
    .elo_i     (elo_1),
    .ehi_i     (ehi_1),
    .thr_i     (thr_i),
    .tnow_i    (tcnt_q),
    .wr_o      (wr),
    .collide_o (collide),
    .kept_o    (kept),
    .grant_o   (grant),
    .rec_o     (new_rec)
  );

  hitfmt_fifo u_fifo (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_i    (wr),
    .rec_i   (new_rec),
    .rd_i    (rec_ready_i),
    .valid_o (rec_valid_o),
    .rec_o   (out_rec),
    .cnt_o   (fifo_cnt),
    .drop_o  (fifo_drop)
  );

  always_comb begin
    tcnt_d = tcnt_q + 1'b1;
    lost_d = lost_q || fifo_drop || collide;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tcnt_q <= '0;
      lost_q <= 1'b0;
      elo_0  <= '0;
      elo_1  <= '0;
      ehi_0  <= '0;
      ehi_1  <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      lost_q <= lost_d;
      elo_0  <= edge_lo_i;
      elo_1  <= elo_0;
      ehi_0  <= edge_hi_i;
      ehi_1  <= ehi_0;
    end
  end

  assign rec_addr_o = out_rec.addr;
  assign rec_time_o = {out_rec.coarse, out_rec.frac};
  assign rec_q_o    = out_rec.q;
  assign rec_ql_o   = out_rec.ql;
  assign rec_qr_o   = out_rec.qr;
  assign lost_o     = lost_q;
endmodule

// File: rtl/hitfmt_chk.sv
module hitfmt_chk
  import hitfmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic              lost_o,
  input logic [CH_N-1:0]   grant,
  input logic [CH_N-1:0]   kept,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic [AD_W-1:0]   rec_addr_o,
  input logic [TIME_W-1:0] rec_time_o,
  input logic [SMP_W-1:0]  rec_q_o
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_q_o)
      && $stable(rec_time_o) && $stable(rec_addr_o)); // R7

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |=> lost_o); // R8

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6

  AST_NO_ADJ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (kept & (kept >> 1)) == '0); // R5

  AST_LOST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_o) |-> (($past(fifo_cnt) == CNT_W'(FIFO_D)) && !$past(rec_ready_i))
      || ($past($countones(kept)) > 1)); // R8
endmodule

bind selftrig_hitfmt hitfmt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .rec_valid_o (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .lost_o      (lost_o),
  .grant       (grant),
  .kept        (kept),
  .fifo_cnt    (fifo_cnt),
  .rec_addr_o  (rec_addr_o),
  .rec_time_o  (rec_time_o),
  .rec_q_o     (rec_q_o)
);

// File: tb/selftrig_hitfmt_bench.sv
`timescale 1ns/100ps
module selftrig_hitfmt_bench;
  import hitfmt_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                       rst_n;
  logic [SMP_W-1:0]           thr_i, edge_lo_i, edge_hi_i;
  logic [CH_N-1:0][SMP_W-1:0] frm;
  logic                       rec_valid_o, rec_ready_i, lost_o;
  logic [AD_W-1:0]            rec_addr_o;
  logic [TIME_W-1:0]          rec_time_o;
  logic [SMP_W-1:0]           rec_q_o, rec_ql_o, rec_qr_o;

  selftrig_hitfmt u_selftrig_hitfmt (
    .clk(clk), .rst_n(rst_n), .thr_i(thr_i), .samples_i(frm),
    .edge_lo_i(edge_lo_i), .edge_hi_i(edge_hi_i),
    .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
    .rec_addr_o(rec_addr_o), .rec_time_o(rec_time_o),
    .rec_q_o(rec_q_o), .rec_ql_o(rec_ql_o), .rec_qr_o(rec_qr_o),
    .lost_o(lost_o)
  );

  // thr, ch, older, peak, newer, left, right, count, exp ch, exp q, exp ql, exp qr, exp frac
  localparam int TV [8][13] = '{
    '{100, 3,  50, 300, 200,  40,  60, 1, 3, 300,  40,  60, 3},
    '{100, 0,  20, 500,   0,  77,  20, 1, 0, 500,  77,  20, 2},
    '{100, 7, 150, 400, 399,  30,  88, 1, 7, 400,  30,  88, 0},
    '{100, 2,  10, 100,   5,   0,   0, 0, 0,   0,   0,   0, 0},
    '{100, 5, 200, 200, 100,   0,   0, 1, 5, 200,   0,   0, 0},
    '{200, 6, 100, 300,   0,   0,   0, 1, 6, 300,   0,   0, 8},
    '{100, 4,  50, 300, 100, 300,   0, 1, 3, 300,   0, 300, 5},
    '{100, 2,  50, 300, 100,   0, 400, 1, 3, 400, 300,   0, 4}
  };

  int checks = 0, fails = 0, fn = 0, got_n = 0;
  bit done = 1'b0;
  int got_addr [32], got_time [32], got_q [32], got_ql [32], got_qr [32];
  logic [CH_N-1:0][SMP_W-1:0] nxt;
  int nlo = 0, nhi = 0, nthr = 100;
  logic nrdy = 1'b1;

  always @(negedge clk) begin
    #1;
    if (rst_n && rec_valid_o && rec_ready_i && got_n < 32) begin
      got_addr[got_n] = int'(rec_addr_o);
      got_time[got_n] = int'(rec_time_o);
      got_q[got_n]    = int'(rec_q_o);
      got_ql[got_n]   = int'(rec_ql_o);
      got_qr[got_n]   = int'(rec_qr_o);
      got_n++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_frame();
    @(negedge clk);
    frm         = nxt;
    edge_lo_i   = SMP_W'(nlo);
    edge_hi_i   = SMP_W'(nhi);
    thr_i       = SMP_W'(nthr);
    rec_ready_i = nrdy;
    fn++;
  endtask

  task automatic zeros(input int n);
    nxt = '0; nlo = 0; nhi = 0;
    repeat (n) put_frame();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frm = '0; nxt = '0; nlo = 0; nhi = 0; nrdy = 1'b1;
    edge_lo_i = '0; edge_hi_i = '0; rec_ready_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    fn = 0;
    got_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ch, sa, base;
    rst_n = 1'b0; thr_i = 12'd100; frm = '0; edge_lo_i = '0; edge_hi_i = '0;
    rec_ready_i = 1'b1; nxt = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 valid in reset", int'(rec_valid_o), 0);
    chk("R9 lost in reset", int'(lost_o), 0);
    do_reset();
    chk("R9 valid after reset", int'(rec_valid_o), 0);
    chk("R9 lost after reset", int'(lost_o), 0);

    // vector table: one pulse per entry
    for (int i = 0; i < 8; i++) begin
      ch = TV[i][1];
      nthr = TV[i][0];
      got_n = 0;
      zeros(3);
      sa = fn;
      nxt = '0; nlo = 0; nhi = 0;
      nxt[ch] = SMP_W'(TV[i][2]);
      put_frame();
      nxt[ch] = SMP_W'(TV[i][3]);
      if (ch > 0) nxt[ch-1] = SMP_W'(TV[i][5]); else nlo = TV[i][5];
      if (ch < CH_N - 1) nxt[ch+1] = SMP_W'(TV[i][6]); else nhi = TV[i][6];
      put_frame();
      nxt = '0; nlo = 0; nhi = 0;
      nxt[ch] = SMP_W'(TV[i][4]);
      put_frame();
      zeros(6);
      chk($sformatf("R2 record count vec%0d", i), got_n, TV[i][7]);
      if (TV[i][7] == 1 && got_n >= 1) begin
        chk($sformatf("R3 R5 addr vec%0d", i), got_addr[0], TV[i][8]);
        chk($sformatf("R1 coarse vec%0d", i), got_time[0] >> FR_W, sa);
        chk($sformatf("R4 frac vec%0d", i), got_time[0] & 15, TV[i][12]);
        chk($sformatf("R3 q vec%0d", i), got_q[0], TV[i][9]);
        chk($sformatf("R3 ql vec%0d", i), got_ql[0], TV[i][10]);
        chk($sformatf("R3 qr vec%0d", i), got_qr[0], TV[i][11]);
      end
    end
    chk("R8 no loss during table", int'(lost_o), 0);

    // R6: two separated channels peak in the same cycle
    nthr = 100; got_n = 0;
    zeros(2);
    nxt = '0; nxt[1] = 12'd300; nxt[5] = 12'd300;
    put_frame();
    zeros(6);
    chk("R6 one record on collision", got_n, 1);
    chk("R6 lowest channel wins", got_addr[0], 1);
    chk("R6 lost set on collision", int'(lost_o), 1);

    // R7/R8: overflow with stalled consumer
    do_reset();
    nthr = 100; nrdy = 1'b0;
    zeros(2);
    base = fn;
    for (int k = 0; k < 6; k++) begin
      nxt = '0; nxt[0] = SMP_W'(300 + 10 * k);
      put_frame();
      zeros(2);
    end
    zeros(4);
    chk("R7 valid held while stalled", int'(rec_valid_o), 1);
    chk("R8 lost after overflow", int'(lost_o), 1);
    chk("R7 nothing popped while stalled", got_n, 0);
    nrdy = 1'b1;
    zeros(8);
    chk("R8 only queue depth kept", got_n, FIFO_D);
    for (int k = 0; k < FIFO_D; k++)
      chk($sformatf("R7 order entry%0d", k), got_q[k], 300 + 10 * k);
    chk("R1 coarse of first queued", got_time[0] >> FR_W, base - 1);
    nxt = '0; nxt[2] = 12'd500;
    put_frame();
    zeros(6);
    chk("R8 detection continues count", got_n, FIFO_D + 1);
    chk("R8 detection continues q", got_q[FIFO_D], 500);
    chk("R8 detection continues addr", got_addr[FIFO_D], 2);
    chk("R8 lost stays set", int'(lost_o), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule